// File: doc/BRIEF.md
# PCI Configuration Window Decoder

This block sits between a host bus and a PCI bus with several card slots. It turns host reads and writes that land in a fixed 64 KB configuration window into type-0 configuration requests. A slot is chosen by which single address bit in offset bits 15:12 is set, and the function by offset bits 11:8. The block then drives a one-hot IDSEL vector, a function number, a dword register offset and byte enables toward the PCI side. It holds the request until the PCI side acknowledges it or reports a master-abort.

The host request channel follows valid/ready rules. A request is taken on a clock edge where `host_req_valid` and `host_req_ready` are both high. `host_req_ready` is high only while the block is idle, so a host that sees it low must keep its request stable. The response channel is valid/ready too. `host_rsp_valid` stays high, and `host_rsp_err` and `host_rsp_rdata` stay unchanged, until the host raises `host_rsp_ready`. After that handshake the block returns to idle on the next cycle.

A request that maps to no slot, no function or no legal byte lane issues no PCI request. It is answered with a bus error in the cycle right after acceptance. A master-abort from the PCI side is reported to the host the same way.

Top module: `cfg_window_decoder`

## Requirements
- R1: A request is decoded only when address bits 31:16 equal 16'hFFFC; any other value gives an error response and no PCI request.
- R2: Offset bits 15:12 must have exactly one bit set. Bit 12+n selects slot n, which drives `pci_idsel` to the value with only bit n set (n = 0..3); zero bits or two or more set bits are an error.
- R3: Offset bits 11:8 give the function: 0 selects function 0, 1 selects function 1 (0x100 above function 0), and any other value is an error.
- R4: `pci_reg` equals address bits 7:2 followed by two zero bits.
- R5: Byte enables follow `host_size`. The encoding is 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A byte access at lane k sets only bit k. A halfword sets 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A word sets 4'b1111. A halfword with address bit 0 set, a word with bits 1:0 nonzero, and size 3 are all errors.
- R6: An access that fails decode raises no `pci_req`, keeps `pci_idsel` at zero, and gives `host_rsp_valid` with `host_rsp_err` = 1 in the cycle after acceptance.
- R7: From acceptance until acknowledge or abort, `pci_req` stays high and `pci_idsel`, `pci_func`, `pci_reg`, `pci_be`, `pci_write` and `pci_wdata` are stable. `host_req_ready` stays low in that time, so host requests are ignored.
- R8: `pci_ack` without `pci_abort` ends the access. In the next cycle `host_rsp_valid` is high with `host_rsp_err` = 0, and for a read `host_rsp_rdata` equals `pci_rdata` as sampled with the acknowledge.
- R9: `pci_abort` during a request yields an error response in the next cycle, and it wins when `pci_ack` is high in the same cycle.
- R10: The response stays valid and unchanged while `host_rsp_ready` is low. The cycle after the response handshake, the block is idle with `host_req_ready` high and `host_rsp_valid` low.
- R11: In reset and directly after it, `host_req_ready` is 1, and `pci_req`, `host_rsp_valid` and `pci_idsel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Block can accept a request |
| host_addr | input | 32 | Host byte address |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | Access size code (see R5) |
| host_wdata | input | 32 | Write data |
| host_rsp_valid | output | 1 | Response valid |
| host_rsp_ready | input | 1 | Host accepts the response |
| host_rsp_err | output | 1 | Response is a bus error |
| host_rsp_rdata | output | 32 | Read data |
| pci_req | output | 1 | Configuration request outstanding |
| pci_write | output | 1 | Request is a write |
| pci_idsel | output | 4 | One-hot slot select |
| pci_func | output | 3 | Function number |
| pci_reg | output | 8 | Dword-aligned register offset |
| pci_be | output | 4 | Byte enables, active high |
| pci_wdata | output | 32 | Write data toward PCI |
| pci_ack | input | 1 | PCI side completed the request |
| pci_abort | input | 1 | PCI side master-abort (no card) |
| pci_rdata | input | 32 | Read data from PCI |

## Verification
The acknowledge and the master-abort can both arrive in the same cycle of an outstanding request. The bench provokes this by raising `pci_ack` and `pci_abort` together on one decoded read, and it requires a bus-error response in the next cycle, as it would for an abort alone. A second overlap is a new host request arriving while a PCI request is still outstanding. Junk requests are offered during every busy window, and the bench checks that `host_req_ready` stays low and that the held IDSEL and request stay unchanged.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/cfgdec_addr.sv
module cfgdec_addr #(
  parameter int TAG_W  = 16,
  parameter logic [TAG_W-1:0] WIN_TAG = 16'hFFFC,
  parameter int SLOT_W = 4,
  parameter int SLOTS  = 4,
  parameter int FN_W   = 4,
  parameter int FUNCS  = 2,
  parameter int REG_W  = 8
) (
  input  logic [TAG_W-1:0]  tag,
  input  logic [SLOT_W-1:0] slot_field,
  input  logic [FN_W-1:0]   fn_field,
  input  logic [REG_W-3:0]  dword_field,
  output logic              addr_ok,
  output logic [SLOTS-1:0]  idsel,
  output logic [2:0]        func,
  output logic [REG_W-1:0]  reg_off
);
  logic win_hit;
  logic slot_ok;
  logic fn_ok;

  // window tag match
  assign win_hit = (tag == WIN_TAG);

  // exactly one select bit, and only within the populated slots
  assign slot_ok = $onehot(slot_field) && ((slot_field >> SLOTS) == '0);
  assign idsel   = slot_field[SLOTS-1:0];

  // function number is the 0x100 step above the slot base
  assign fn_ok = (fn_field < FN_W'(FUNCS));
  assign func  = 3'(fn_field);

  assign reg_off = {dword_field, 2'b00};
  assign addr_ok = win_hit && slot_ok && fn_ok;
endmodule

// File: rtl/cfgdec_lanes.sv
module cfgdec_lanes
  import cfgdec_pkg::*;
#(
  parameter int LANES   = 4,
  localparam int LANE_AW = $clog2(LANES)
) (
  input  logic [1:0]         size,
  input  logic [LANE_AW-1:0] lane_addr,
  output logic [LANES-1:0]   be,
  output logic               lane_ok
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LANE_AW-1:0] LANE_IDX = LANE_AW'(i);
    localparam logic [LANE_AW-1:0] HALF_IDX = LANE_AW'(i >> 1);
    always_comb begin
      case (xfer_size_e'(size))
        SZ_BYTE: be[i] = (lane_addr == LANE_IDX);
        SZ_HALF: be[i] = ((lane_addr >> 1) == HALF_IDX);
        SZ_WORD: be[i] = 1'b1;
        default: be[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (xfer_size_e'(size))
      SZ_BYTE: lane_ok = 1'b1;
      SZ_HALF: lane_ok = (lane_addr[0] == 1'b0);
      SZ_WORD: lane_ok = (lane_addr == '0);
      default: lane_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfgdec_seq.sv
module cfgdec_seq
  import cfgdec_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int REG_W  = 8,
  parameter int LANES  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              dec_ok,
  input  logic [SLOTS-1:0]  dec_idsel,
  input  logic [2:0]        dec_func,
  input  logic [REG_W-1:0]  dec_reg,
  input  logic [LANES-1:0]  dec_be,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              pci_req,
  output logic              pci_write,
  output logic [SLOTS-1:0]  pci_idsel,
  output logic [2:0]        pci_func,
  output logic [REG_W-1:0]  pci_reg,
  output logic [LANES-1:0]  pci_be,
  output logic [DATA_W-1:0] pci_wdata,
  input  logic              pci_ack,
  input  logic              pci_abort,
  input  logic [DATA_W-1:0] pci_rdata
);
  seq_state_e        state;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;
  logic [SLOTS-1:0]  idsel_q;
  logic [2:0]        func_q;
  logic [REG_W-1:0]  reg_q;
  logic [LANES-1:0]  be_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      err_q   <= 1'b0;
      rdata_q <= '0;
      idsel_q <= '0;
      func_q  <= '0;
      reg_q   <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            func_q  <= dec_func;
            reg_q   <= dec_reg;
            be_q    <= dec_be;
            rdata_q <= '0;
            if (dec_ok) begin
              idsel_q <= dec_idsel;
              err_q   <= 1'b0;
              state   <= ST_BUSY;
            end else begin
              err_q <= 1'b1;
              state <= ST_RESP;
            end
          end
        end
        ST_BUSY: begin
          if (pci_abort) begin
            err_q   <= 1'b1;
            idsel_q <= '0;
            state   <= ST_RESP;
          end else if (pci_ack) begin
            err_q   <= 1'b0;
            rdata_q <= pci_rdata;
            idsel_q <= '0;
            state   <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign pci_req   = (state == ST_BUSY);
  assign pci_idsel = idsel_q;
  assign pci_func  = func_q;
  assign pci_reg   = reg_q;
  assign pci_be    = be_q;
  assign pci_write = wr_q;
  assign pci_wdata = wdata_q;
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int WIN_SHIFT = 16,
  parameter logic [ADDR_W-WIN_SHIFT-1:0] WIN_TAG = 16'hFFFC,
  parameter int SLOT_LSB  = 12,
  parameter int SLOTS     = 4,
  parameter int FUNC_LSB  = 8,
  parameter int FUNCS     = 2,
  localparam int TAG_W    = ADDR_W - WIN_SHIFT,
  localparam int SLOT_W   = WIN_SHIFT - SLOT_LSB,
  localparam int FN_W     = SLOT_LSB - FUNC_LSB,
  localparam int REG_W    = FUNC_LSB,
  localparam int LANES    = DATA_W / 8,
  localparam int LANE_AW  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_write,
  input  logic [1:0]        host_size,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic              host_rsp_err,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              pci_req,
  output logic              pci_write,
  output logic [SLOTS-1:0]  pci_idsel,
  output logic [2:0]        pci_func,
  output logic [REG_W-1:0]  pci_reg,
  output logic [LANES-1:0]  pci_be,
  output logic [DATA_W-1:0] pci_wdata,
  input  logic              pci_ack,
  input  logic              pci_abort,
  input  logic [DATA_W-1:0] pci_rdata
);
  logic             addr_ok;
  logic             lane_ok;
  logic [SLOTS-1:0] dec_idsel;
  logic [2:0]       dec_func;
  logic [REG_W-1:0] dec_reg;
  logic [LANES-1:0] dec_be;

  cfgdec_addr #(
    .TAG_W  (TAG_W),
    .WIN_TAG(WIN_TAG),
    .SLOT_W (SLOT_W),
    .SLOTS  (SLOTS),
    .FN_W   (FN_W),
    .FUNCS  (FUNCS),
    .REG_W  (REG_W)
  ) u_addr (
    .tag        (host_addr[ADDR_W-1:WIN_SHIFT]),
    .slot_field (host_addr[WIN_SHIFT-1:SLOT_LSB]),
    .fn_field   (host_addr[SLOT_LSB-1:FUNC_LSB]),
    .dword_field(host_addr[FUNC_LSB-1:2]),
    .addr_ok    (addr_ok),
    .idsel      (dec_idsel),
    .func       (dec_func),
    .reg_off    (dec_reg)
  );

  cfgdec_lanes #(
    .LANES(LANES)
  ) u_lanes (
    .size     (host_size),
    .lane_addr(host_addr[LANE_AW-1:0]),
    .be       (dec_be),
    .lane_ok  (lane_ok)
  );

  cfgdec_seq #(
    .SLOTS (SLOTS),
    .REG_W (REG_W),
    .LANES (LANES),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(host_req_valid),
    .req_ready(host_req_ready),
    .dec_ok   (addr_ok && lane_ok),
    .dec_idsel(dec_idsel),
    .dec_func (dec_func),
    .dec_reg  (dec_reg),
    .dec_be   (dec_be),
    .req_write(host_write),
    .req_wdata(host_wdata),
    .rsp_valid(host_rsp_valid),
    .rsp_ready(host_rsp_ready),
    .rsp_err  (host_rsp_err),
    .rsp_rdata(host_rsp_rdata),
    .pci_req  (pci_req),
    .pci_write(pci_write),
    .pci_idsel(pci_idsel),
    .pci_func (pci_func),
    .pci_reg  (pci_reg),
    .pci_be   (pci_be),
    .pci_wdata(pci_wdata),
    .pci_ack  (pci_ack),
    .pci_abort(pci_abort),
    .pci_rdata(pci_rdata)
  );
endmodule

// File: rtl/cfgdec_chk.sv
module cfgdec_chk #(
  parameter int TAG_W  = 16,
  parameter logic [TAG_W-1:0] WIN_TAG = 16'hFFFC,
  parameter int SLOTS  = 4,
  parameter int REG_W  = 8,
  parameter int LANES  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_req_valid,
  input logic              host_req_ready,
  input logic [TAG_W-1:0]  addr_tag,
  input logic              host_rsp_valid,
  input logic              host_rsp_ready,
  input logic              host_rsp_err,
  input logic [DATA_W-1:0] host_rsp_rdata,
  input logic              pci_req,
  input logic [SLOTS-1:0]  pci_idsel,
  input logic [2:0]        pci_func,
  input logic [REG_W-1:0]  pci_reg,
  input logic [LANES-1:0]  pci_be,
  input logic              pci_ack,
  input logic              pci_abort
);
  assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_valid && host_req_ready && addr_tag != WIN_TAG)
      |=> (host_rsp_valid && host_rsp_err && !pci_req));

  assert_idsel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req |-> ($countones(pci_idsel) == 1));

  assert_idle_no_idsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_req |-> (pci_idsel == '0));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req && !pci_ack && !pci_abort)
      |=> (pci_req && $stable(pci_idsel) && $stable(pci_func)
           && $stable(pci_reg) && $stable(pci_be)));

  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req |-> !host_req_ready);

  assert_ack_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req && pci_ack && !pci_abort) |=> (host_rsp_valid && !host_rsp_err));

  assert_abort_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req && pci_abort) |=> (host_rsp_valid && host_rsp_err));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && !host_rsp_ready)
      |=> (host_rsp_valid && $stable(host_rsp_err) && $stable(host_rsp_rdata)));
endmodule

bind cfg_window_decoder cfgdec_chk #(
  .TAG_W  (TAG_W),
  .WIN_TAG(WIN_TAG),
  .SLOTS  (SLOTS),
  .REG_W  (REG_W),
  .LANES  (LANES),
  .DATA_W (DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_req_valid(host_req_valid),
  .host_req_ready(host_req_ready),
  .addr_tag      (host_addr[ADDR_W-1:WIN_SHIFT]),
  .host_rsp_valid(host_rsp_valid),
  .host_rsp_ready(host_rsp_ready),
  .host_rsp_err  (host_rsp_err),
  .host_rsp_rdata(host_rsp_rdata),
  .pci_req       (pci_req),
  .pci_idsel     (pci_idsel),
  .pci_func      (pci_func),
  .pci_reg       (pci_reg),
  .pci_be        (pci_be),
  .pci_ack       (pci_ack),
  .pci_abort     (pci_abort)
);

// File: tb/sim_cfg_window_decoder.sv
module sim_cfg_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic [31:0] host_addr = '0;
  logic        host_write = 1'b0;
  logic [1:0]  host_size = 2'd2;
  logic [31:0] host_wdata = '0;
  logic        host_rsp_valid;
  logic        host_rsp_ready = 1'b1;
  logic        host_rsp_err;
  logic [31:0] host_rsp_rdata;
  logic        pci_req;
  logic        pci_write;
  logic [3:0]  pci_idsel;
  logic [2:0]  pci_func;
  logic [7:0]  pci_reg;
  logic [3:0]  pci_be;
  logic [31:0] pci_wdata;
  logic        pci_ack = 1'b0;
  logic        pci_abort = 1'b0;
  logic [31:0] pci_rdata = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cfg_window_decoder u0 (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_addr(host_addr), .host_write(host_write), .host_size(host_size),
    .host_wdata(host_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_ready(host_rsp_ready),
    .host_rsp_err(host_rsp_err), .host_rsp_rdata(host_rsp_rdata),
    .pci_req(pci_req), .pci_write(pci_write), .pci_idsel(pci_idsel),
    .pci_func(pci_func), .pci_reg(pci_reg), .pci_be(pci_be),
    .pci_wdata(pci_wdata), .pci_ack(pci_ack), .pci_abort(pci_abort),
    .pci_rdata(pci_rdata)
  );

  // mode: 0 ack, 1 abort, 3 ack and abort together
  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic [1:0]  mode;
    logic        derr;
    logic [3:0]  idsel;
    logic [2:0]  func;
    logic [7:0]  rg;
    logic [3:0]  be;
  } vec_t;

  localparam int NV = 14;
  localparam logic [56:0] VECS [NV] = '{
    {32'hFFFC1000, 2'd2, 1'b0, 2'd0, 1'b0, 4'b0001, 3'd0, 8'h00, 4'hF},
    {32'hFFFC2104, 2'd2, 1'b1, 2'd0, 1'b0, 4'b0010, 3'd1, 8'h04, 4'hF},
    {32'hFFFC400A, 2'd1, 1'b0, 2'd0, 1'b0, 4'b0100, 3'd0, 8'h08, 4'hC},
    {32'hFFFC8013, 2'd0, 1'b1, 2'd0, 1'b0, 4'b1000, 3'd0, 8'h10, 4'h8},
    {32'hFFFC41FC, 2'd2, 1'b0, 2'd0, 1'b0, 4'b0100, 3'd1, 8'hFC, 4'hF},
    {32'hFFFC1100, 2'd0, 1'b0, 2'd0, 1'b0, 4'b0001, 3'd1, 8'h00, 4'h1},
    {32'hFFFC1200, 2'd2, 1'b0, 2'd0, 1'b1, 4'b0000, 3'd0, 8'h00, 4'h0},
    {32'hFFFC0000, 2'd2, 1'b0, 2'd0, 1'b1, 4'b0000, 3'd0, 8'h00, 4'h0},
    {32'hFFFC3000, 2'd2, 1'b1, 2'd0, 1'b1, 4'b0000, 3'd0, 8'h00, 4'h0},
    {32'hFFFD1000, 2'd2, 1'b0, 2'd0, 1'b1, 4'b0000, 3'd0, 8'h00, 4'h0},
    {32'hFFFC1002, 2'd2, 1'b0, 2'd0, 1'b1, 4'b0000, 3'd0, 8'h00, 4'h0},
    {32'hFFFC1000, 2'd3, 1'b0, 2'd0, 1'b1, 4'b0000, 3'd0, 8'h00, 4'h0},
    {32'hFFFC8101, 2'd1, 1'b0, 2'd0, 1'b1, 4'b0000, 3'd0, 8'h00, 4'h0},
    {32'hFFFC2000, 2'd2, 1'b0, 2'd1, 1'b0, 4'b0010, 3'd0, 8'h00, 4'hF}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run_txn(input vec_t v, input int hold);
    logic [31:0] exp_rd;
    logic [3:0]  held_idsel;
    exp_rd = {8'hC5, 4'h0, v.idsel, 5'h0, v.func, v.rg};
    @(negedge clk);
    host_req_valid = 1'b1;
    host_addr  = v.addr;
    host_size  = v.size;
    host_write = v.wr;
    host_wdata = v.addr ^ 32'h5A5A_5A5A;
    host_rsp_ready = (hold == 0);
    @(negedge clk);
    host_req_valid = 1'b0;
    if (v.derr) begin
      chk("R6 no pci_req on decode error", {63'd0, pci_req}, 64'd0);
      chk("R6 idsel zero on decode error", {60'd0, pci_idsel}, 64'd0);
      chk("R1 R2 R3 R5 error response", {62'd0, host_rsp_valid, host_rsp_err}, 64'd3);
    end else begin
      chk("R7 pci_req raised", {63'd0, pci_req}, 64'd1);
      chk("R2 idsel slot", {60'd0, pci_idsel}, {60'd0, v.idsel});
      chk("R3 function", {61'd0, pci_func}, {61'd0, v.func});
      chk("R4 register offset", {56'd0, pci_reg}, {56'd0, v.rg});
      chk("R5 byte enables", {60'd0, pci_be}, {60'd0, v.be});
      chk("R7 write flag", {63'd0, pci_write}, {63'd0, v.wr});
      if (v.wr) chk("R7 write data", {32'd0, pci_wdata}, {32'd0, v.addr ^ 32'h5A5A_5A5A});
      held_idsel = pci_idsel;
      host_req_valid = 1'b1;
      host_addr  = 32'hFFFC8000;
      host_write = ~v.wr;
      host_size  = 2'd2;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk("R7 request held, host ignored",
            {61'd0, pci_req, host_req_ready, host_rsp_valid}, 64'd4);
        chk("R7 idsel stable", {60'd0, pci_idsel}, {60'd0, held_idsel});
      end
      host_req_valid = 1'b0;
      pci_rdata = {8'hC5, 4'h0, pci_idsel, 5'h0, pci_func, pci_reg};
      pci_ack   = (v.mode != 2'd1);
      pci_abort = (v.mode != 2'd0);
      @(negedge clk);
      pci_ack   = 1'b0;
      pci_abort = 1'b0;
      chk("R8 R9 response valid", {63'd0, host_rsp_valid}, 64'd1);
      chk("R8 R9 response error", {63'd0, host_rsp_err}, {63'd0, v.mode != 2'd0});
      chk("R8 pci_req dropped", {63'd0, pci_req}, 64'd0);
      if (v.mode == 2'd0 && !v.wr)
        chk("R8 read data", {32'd0, host_rsp_rdata}, {32'd0, exp_rd});
    end
    if (hold > 0) begin
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk("R10 response held under back-pressure",
            {62'd0, host_rsp_valid, host_req_ready}, 64'd2);
        chk("R10 error flag held", {63'd0, host_rsp_err},
            {63'd0, (v.derr || v.mode != 2'd0)});
        if (!v.derr && v.mode == 2'd0 && !v.wr)
          chk("R10 read data held", {32'd0, host_rsp_rdata}, {32'd0, exp_rd});
      end
      host_rsp_ready = 1'b1;
    end
    @(negedge clk);
    chk("R10 back to idle", {62'd0, host_rsp_valid, host_req_ready}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vec_t v;
    repeat (2) @(negedge clk);
    chk("R11 ready in reset", {63'd0, host_req_ready}, 64'd1);
    chk("R11 quiet in reset", {58'd0, pci_req, host_rsp_valid, pci_idsel}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", {63'd0, host_req_ready}, 64'd1);
    chk("R11 quiet after reset", {58'd0, pci_req, host_rsp_valid, pci_idsel}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VECS[i]);
      run_txn(v, 0);
    end

    // R9: acknowledge and abort in the same cycle, abort wins
    v = vec_t'({32'hFFFC8000, 2'd2, 1'b0, 2'd3, 1'b0, 4'b1000, 3'd0, 8'h00, 4'hF});
    run_txn(v, 0);
    // R10: back-pressure on a good read and on a decode error
    v = vec_t'(VECS[4]);
    run_txn(v, 2);
    v = vec_t'(VECS[7]);
    run_txn(v, 3);
    // R1: window tag off by the top bit
    v = vec_t'({32'h7FFC1000, 2'd2, 1'b0, 2'd0, 1'b1, 4'b0000, 3'd0, 8'h00, 4'h0});
    run_txn(v, 0);

    finish_run();
  end
endmodule